// File: doc/BRIEF.md
# Down-Counting Horizontal Timing Generator

This block produces the horizontal timing of a raster display line. A position counter loads a programmable line total, steps down by one every clock and reloads when it reaches zero, so each line lasts the total plus one clocks. Three programmable windows are set and cleared by equality compares against the counter value. The windows are an active-low sync pulse, a horizontal active window and a horizontal clock-gate window. Each window turns on when the counter equals its start value and turns off when the counter equals its stop value. Because the windows are set/clear state rather than range checks, a window may run through the reload point.

Software writes the line total and the three start/stop pairs through a plain register port. A write lands in a shadow copy at once and reads back at once. The compare logic only picks up the shadow copy at the line reload, so no line is ever cut by a change in the middle of the line. The active-video output is the OR of an external vertical-active input and the internal horizontal active window. The current counter value is brought out for neighbouring fetch logic.

When clock gating is used, software programs the active window at the gate window's values plus 5. Because the counter runs downward, the active window then opens and closes exactly 5 clocks ahead of the gate window. The register port is a plain control interface with no back-pressure: a write completes in the cycle `reg_we` is high, and `reg_rdata` follows `reg_addr` combinationally.

Top module: `hwin_timing_gen`

## Requirements
- R1: After reset, every register reads 0, `h_count` is 0, `hsync_n` is 1, and `h_active` and `hclk_gate` are 0.
- R2: `h_count` decrements by one every clock. When it is 0, the next value is the line total currently written, so a line lasts total+1 clocks.
- R3: `hsync_n` goes low in the clock after `h_count` equals the live sync start. It goes high in the clock after `h_count` equals the live sync stop. If start equals stop, stop wins and no pulse appears.
- R4: `h_active` goes high in the clock after `h_count` equals the live active start. It goes low in the clock after `h_count` equals the live active stop. Stop wins on equality.
- R5: `hclk_gate` follows the same set/clear rule, using the live gate start and gate stop values.
- R6: `vid_active` equals `v_active` OR `h_active` in every cycle, with no added latency.
- R7: Register map by `reg_addr`: 0 is the line total in bits 10:0, 1 is sync, 2 is active and 3 is gate. In each start/stop register the start value is in bits 10:0 and the stop value is in bits 26:16. All other bits read 0, even after writing 1s.
- R8: A register write changes no window compare until the clock in which `h_count` is 0 has passed. The rest of the current line keeps the old values.
- R9: A window whose start comes before zero and whose stop comes after the reload stays active across the reload.
- R10: With the active values programmed to the gate values plus 5, `h_active` rises exactly 5 clocks before `hclk_gate` rises and falls exactly 5 clocks before `hclk_gate` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 total, 1 sync, 2 active, 3 gate) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| v_active | input | 1 | Vertical active window from the vertical timing logic |
| h_count | output | 11 | Current horizontal down-counter value |
| hsync_n | output | 1 | Horizontal sync, active low |
| h_active | output | 1 | Horizontal active window, registered |
| hclk_gate | output | 1 | Horizontal clock-gate window, registered |
| vid_active | output | 1 | Active-video interval (`v_active` OR `h_active`) |

## Verification
A table of line totals and start/stop pairs drives the active window. The pairs cover an ordinary window with start above stop, a window that wraps through the reload, equal start and stop, and values at the two ends of the count range. For each pair, the counter values at which the edges occur show whether the set and clear compares are swapped, off by one, or wrongly given priority. Directed cases cover the following:
- The sync pulse and its inverted polarity.
- The 5-count offset between the gate and active windows.
- A write in the middle of a line, which tells deferred loading apart from immediate loading.
- Reads of reserved bits and the OR with the vertical input.

// File: rtl/hwin_pkg.sv
package hwin_pkg;
  localparam int NUM_WIN = 3;
  localparam int WIN_SYNC = 0;
  localparam int WIN_ACT  = 1;
  localparam int WIN_GATE = 2;

  typedef enum logic [1:0] {
    ADDR_TOTAL = 2'd0,
    ADDR_SYNC  = 2'd1,
    ADDR_ACT   = 2'd2,
    ADDR_GATE  = 2'd3
  } hwin_addr_e;
endpackage

// File: rtl/hwin_regs.sv
module hwin_regs
  import hwin_pkg::*;
#(
  parameter int CNT_W    = 11,
  parameter int DATA_W   = 32,
  parameter int STOP_LSB = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [1:0]                      addr,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [DATA_W-1:0]               rd_data,
  input  logic                            reload,
  output logic [CNT_W-1:0]                total_sh,
  output logic [NUM_WIN-1:0][CNT_W-1:0]   start_live,
  output logic [NUM_WIN-1:0][CNT_W-1:0]   stop_live
);
  logic [NUM_WIN-1:0][CNT_W-1:0] start_sh;
  logic [NUM_WIN-1:0][CNT_W-1:0] stop_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) total_sh <= '0;
    else if (wr_en && addr == ADDR_TOTAL) total_sh <= wr_data[CNT_W-1:0];
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win_reg
    localparam logic [1:0] MY_ADDR = 2'(w + 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_sh[w] <= '0;
        stop_sh[w]  <= '0;
      end else if (wr_en && addr == MY_ADDR) begin
        start_sh[w] <= wr_data[CNT_W-1:0];
        stop_sh[w]  <= wr_data[STOP_LSB +: CNT_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_live[w] <= '0;
        stop_live[w]  <= '0;
      end else if (reload) begin
        start_live[w] <= start_sh[w];
        stop_live[w]  <= stop_sh[w];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      ADDR_TOTAL: rd_data[CNT_W-1:0] = total_sh;
      default: begin
        rd_data[CNT_W-1:0]           = start_sh[addr - 2'd1];
        rd_data[STOP_LSB +: CNT_W]   = stop_sh[addr - 2'd1];
      end
    endcase
  end

  // R8: compare values move only on a reload cycle
  a_r8_live_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> ($stable(start_live) && $stable(stop_live)));

  // R7: the read data never carries a reserved bit
  a_r7_rsvd_zero : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[STOP_LSB-1:CNT_W] == '0) && (rd_data[DATA_W-1:STOP_LSB+CNT_W] == '0));
endmodule

// File: rtl/hwin_counter.sv
module hwin_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] total,
  output logic [CNT_W-1:0] cnt_q,
  output logic             reload
);
  assign reload = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (reload) cnt_q <= total;
    else cnt_q <= cnt_q - 1'b1;
  end

  // R2: step down by one away from zero
  a_r2_step_down : assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R2: zero reloads the programmed total
  a_r2_reload_total : assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |=> (cnt_q == $past(total)));
endmodule

// File: rtl/hwin_window.sv
module hwin_window #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] start_val,
  input  logic [CNT_W-1:0] stop_val,
  output logic             win_q
);
  logic hit_start;
  logic hit_stop;

  assign hit_start = (cnt == start_val);
  assign hit_stop  = (cnt == stop_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= 1'b0;
    else if (hit_stop) win_q <= 1'b0;
    else if (hit_start) win_q <= 1'b1;
  end

  // R3 R4 R5: start compare opens the window a cycle later
  a_r4_open : assert property (@(posedge clk) disable iff (!rst_n)
    (hit_start && !hit_stop) |=> win_q);

  // R3 R4 R5: stop compare closes it, and wins a tie
  a_r4_close : assert property (@(posedge clk) disable iff (!rst_n)
    hit_stop |=> !win_q);

  // R9: without a compare the window holds, including across reload
  a_r9_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_start && !hit_stop) |=> $stable(win_q));
endmodule

// File: rtl/hwin_timing_gen.sv
module hwin_timing_gen
  import hwin_pkg::*;
#(
  parameter int CNT_W    = 11,
  parameter int DATA_W   = 32,
  parameter int STOP_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              v_active,
  output logic [CNT_W-1:0]  h_count,
  output logic              hsync_n,
  output logic              h_active,
  output logic              hclk_gate,
  output logic              vid_active
);
  logic                          reload;
  logic [CNT_W-1:0]              total_sh;
  logic [NUM_WIN-1:0][CNT_W-1:0] start_live;
  logic [NUM_WIN-1:0][CNT_W-1:0] stop_live;
  logic [NUM_WIN-1:0]            win;

  hwin_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .STOP_LSB(STOP_LSB)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_we),
    .addr       (reg_addr),
    .wr_data    (reg_wdata),
    .rd_data    (reg_rdata),
    .reload     (reload),
    .total_sh   (total_sh),
    .start_live (start_live),
    .stop_live  (stop_live)
  );

  hwin_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .total  (total_sh),
    .cnt_q  (h_count),
    .reload (reload)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    hwin_window #(.CNT_W(CNT_W)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt       (h_count),
      .start_val (start_live[w]),
      .stop_val  (stop_live[w]),
      .win_q     (win[w])
    );
  end

  assign hsync_n    = ~win[WIN_SYNC];
  assign h_active   = win[WIN_ACT];
  assign hclk_gate  = win[WIN_GATE];
  assign vid_active = v_active | win[WIN_ACT];

  // R1: outputs idle right after reset release
  a_r1_idle_after_reset : assert property (@(posedge clk)
    $rose(rst_n) |-> (hsync_n && !h_active && !hclk_gate));
endmodule

// File: tb/tb_hwin_timing_gen.sv
module tb_hwin_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        v_active = 1'b0;
  logic [10:0] h_count;
  logic        hsync_n, h_active, hclk_gate, vid_active;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwin_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .v_active(v_active),
    .h_count(h_count), .hsync_n(hsync_n), .h_active(h_active),
    .hclk_gate(hclk_gate), .vid_active(vid_active)
  );

  typedef struct packed {
    logic [10:0] total;
    logic [10:0] start;
    logic [10:0] stop;
  } vec_t;

  localparam int VEC_N = 5;
  localparam vec_t VECS [VEC_N] = '{
    '{11'd99, 11'd80, 11'd20},   // plain window, R4
    '{11'd99, 11'd10, 11'd90},   // wraps through reload, R9
    '{11'd99, 11'd50, 11'd50},   // tie, stop wins, R4
    '{11'd99, 11'd99, 11'd0},    // range ends, R4
    '{11'd30, 11'd25, 11'd3}     // other total, R4
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] pair(input int start, input int stop);
    return (32'(stop) << 16) | 32'(start);
  endfunction

  function automatic logic pick(input int sel);
    case (sel)
      0: return ~hsync_n;
      1: return h_active;
      default: return hclk_gate;
    endcase
  endfunction

  task automatic wait_zero();
    do @(negedge clk); while (h_count != 0);
  endtask

  // Waits one full line to settle, then watches one line of a window.
  task automatic measure(input int sel, input int total,
                         output bit rise_seen, output int rise_prev, output int rise_idx,
                         output bit fall_seen, output int fall_prev, output int fall_idx);
    int  prev_cnt;
    logic prev_v;
    wait_zero();
    @(negedge clk);
    wait_zero();
    prev_cnt = h_count; prev_v = pick(sel);
    rise_seen = 0; fall_seen = 0;
    rise_prev = -1; fall_prev = -1; rise_idx = -1; fall_idx = -1;
    for (int i = 0; i <= total; i++) begin
      @(negedge clk);
      if (!prev_v && pick(sel) && !rise_seen) begin
        rise_seen = 1; rise_prev = prev_cnt; rise_idx = i;
      end
      if (prev_v && !pick(sel) && !fall_seen) begin
        fall_seen = 1; fall_prev = prev_cnt; fall_idx = i;
      end
      prev_cnt = h_count; prev_v = pick(sel);
    end
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    bit rs, fs;
    int rp, ri, fp, fi;
    int a_ri, a_fi, g_ri, g_fi;
    int len, prev_cnt;
    bit step_ok;

    repeat (3) @(negedge clk);
    // R1 during and after reset
    check(hsync_n && !h_active && !hclk_gate, "R1 outputs in reset",
          {hsync_n, h_active, hclk_gate}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(h_count == 0, "R1 counter", h_count, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check(d == 0, "R1 register reset", d, 0);
    end

    // R6 with h_active low
    v_active = 1'b1; #1;
    check(vid_active == 1'b1, "R6 vertical only", vid_active, 1);
    v_active = 1'b0; #1;
    check(vid_active == 1'b0, "R6 both low", vid_active, 0);

    // R7 reserved bits and field placement
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d);
    check(d == 32'h07FF_07FF, "R7 reserved bits read zero", d, 32'h07FF_07FF);
    wr(2'd0, 32'hFFFF_F863);
    rd(2'd0, d);
    check(d == 32'd99, "R7 total field", d, 99);
    wr(2'd1, pair(90, 80));
    rd(2'd1, d);
    check(d == pair(90, 80), "R7 sync start/stop placement", d, pair(90, 80));

    // R2 line length and stepping
    wait_zero();
    @(negedge clk);
    wait_zero();
    len = 0; step_ok = 1; prev_cnt = 0;
    do begin
      @(negedge clk);
      if (len > 0 && h_count != 11'(prev_cnt - 1)) step_ok = 0;
      if (len == 0 && h_count != 99) step_ok = 0;
      prev_cnt = h_count;
      len++;
    end while (h_count != 0);
    check(len == 100, "R2 line length", len, 100);
    check(step_ok, "R2 decrement and reload", step_ok, 1);

    // R3 sync pulse, active low
    measure(0, 99, rs, rp, ri, fs, fp, fi);
    check(rs && rp == 90, "R3 sync asserts at start", rp, 90);
    check(fs && fp == 80, "R3 sync releases at stop", fp, 80);

    // R4 / R9 vector table on the active window
    for (int v = 0; v < VEC_N; v++) begin
      wr(2'd0, 32'(VECS[v].total));
      wr(2'd2, pair(VECS[v].start, VECS[v].stop));
      measure(1, VECS[v].total, rs, rp, ri, fs, fp, fi);
      if (VECS[v].start == VECS[v].stop) begin
        check(!rs && !fs && !h_active, "R4 equal start/stop gives no window", {rs, fs}, 0);
      end else begin
        check(rs && rp == VECS[v].start, "R4 R9 active rise count", rp, VECS[v].start);
        check(fs && fp == VECS[v].stop, "R4 R9 active fall count", fp, VECS[v].stop);
      end
    end

    // R5 and R10: gate window and the plus-5 offset
    wr(2'd0, 32'd99);
    wr(2'd3, pair(60, 30));
    wr(2'd2, pair(65, 35));
    measure(2, 99, rs, rp, g_ri, fs, fp, g_fi);
    check(rs && rp == 60, "R5 gate rise count", rp, 60);
    check(fs && fp == 30, "R5 gate fall count", fp, 30);
    measure(1, 99, rs, rp, a_ri, fs, fp, a_fi);
    check(a_ri + 5 == g_ri, "R10 active rises 5 before gate", g_ri - a_ri, 5);
    check(a_fi + 5 == g_fi, "R10 active falls 5 before gate", g_fi - a_fi, 5);

    // R6 with h_active high and v_active low
    do @(negedge clk); while (!h_active);
    check(vid_active == 1'b1, "R6 horizontal only", vid_active, 1);

    // R8 mid-line write is deferred
    wr(2'd2, pair(80, 20));
    wait_zero();
    @(negedge clk);
    do @(negedge clk); while (h_count != 70);
    wr(2'd2, pair(50, 40));
    fs = 0; fp = -1; prev_cnt = h_count;
    while (h_count != 0) begin
      logic pv;
      pv = h_active;
      @(negedge clk);
      if (pv && !h_active && !fs) begin fs = 1; fp = prev_cnt; end
      prev_cnt = h_count;
    end
    check(fs && fp == 20, "R8 old stop used for rest of line", fp, 20);
    measure(1, 99, rs, rp, ri, fs, fp, fi);
    check(rs && rp == 50 && fs && fp == 40, "R8 new values on next line", fp, 40);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule